// File: doc/BRIEF.md
# Low-Speed USB Packet Serializer

This block turns a short list of ready-made packet bytes into the differential line signals of a low-speed USB transmitter. A single start pulse, sampled while the block is idle, carries the total byte count. That count lies between 2 and 12 and includes the sync byte, which the block makes itself. The data bytes that follow it are fetched one at a time through a small read port. The fetch address starts at 0 and counts up. The memory behind the port answers in the same cycle.

The serializer first takes the bus and holds the idle J level for one bit period. It then shifts out the sync byte and the data bytes least significant bit first. Each bit is NRZI encoded, and a toggle is stuffed in after every run of six ones. The packet ends with an end-of-packet sequence, after which the pins are released with both levels forced low. A busy flag covers the whole transfer, and a one-cycle done strobe marks the release. The bit period is a whole number of clock cycles. No fractional correction is applied, because the line only has to stay within 1.5 percent of the nominal rate.

Top module: `usb_ls_tx`

## Requirements
- R1: During and after reset, oe_o, dp_o, dm_o, busy_o and done_o are all 0.
- R2: A start_i seen while idle is taken at that clock edge. From that edge busy_o is 1 and oe_o is 1, and the lines show J (dp_o=0, dm_o=1) for one full bit period before the first data symbol.
- R3: The symbols after the leading J carry the byte 0x80 first and then the bytes read at addresses 0 to N-2, each least significant bit first, where N (2..12) is the nbytes_i value taken with the start.
- R4: The encoding is NRZI. A 0 bit changes the line between J (dp=0, dm=1) and K (dp=1, dm=0), and a 1 bit keeps the level of the previous symbol. The level before the first bit is J.
- R5: After six consecutive 1 bits, one extra toggling symbol is inserted before anything else is sent. This applies across byte boundaries and also after the final bit. The count of ones starts from zero in every packet.
- R6: Every symbol, including the leading J, the SE0 symbols and the trailing J, lasts exactly CLKS_PER_BIT clock cycles.
- R7: After the last data or stuffed symbol, both lines are driven low for exactly two bit periods, and then J is driven for one bit period.
- R8: At the end of the trailing J, in the same cycle, oe_o, dp_o, dm_o and busy_o fall to 0, and done_o is 1 for exactly one cycle.
- R9: A start_i that arrives while busy_o is 1 is ignored. The packet in progress keeps its byte count, its symbols and its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled only when idle |
| nbytes_i | input | 4 | Byte count including the sync byte (2..12) |
| rd_addr_o | output | 4 | Address of the next data byte |
| rd_data_i | input | 8 | Data byte at rd_addr_o, combinational |
| dp_o | output | 1 | D+ level |
| dm_o | output | 1 | D- level |
| oe_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the bus is released |

## Verification
The assertions take it as given that a start taken while idle carries a byte count between 2 and 12. They also take it as given that the byte at rd_addr_o is valid in the same cycle, without wait states. The bench drives only counts within that range. It serves the read port from a combinational array that stays unchanged while a packet is in flight. Its one start issued during a transfer carries a different count, which must leave the packet unchanged.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_LEAD_J,
    TX_BITS,
    TX_SE0,
    TX_TAIL_J
  } tx_state_t;

  localparam logic [7:0] SYNC_PATTERN = 8'h80;
  localparam logic       LVL_J        = 1'b0;
endpackage

// File: rtl/usb_ls_bit_timer.sv
module usb_ls_bit_timer #(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end

  assign tick = run && (cnt == LAST);

  // A bit period is never shorter than two clocks, so ticks never touch.
  assert_tick_gap_R6: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/usb_ls_nrzi.sv
module usb_ls_nrzi #(
  parameter int STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  input  logic data_bit,
  output logic stuff_due,
  output logic lvl_next
);
  import usb_ls_tx_pkg::*;
  localparam int OW = $clog2(STUFF_RUN + 1);

  logic          lvl;
  logic [OW-1:0] ones;
  logic          flip;

  assign stuff_due = (ones == OW'(STUFF_RUN));
  assign flip      = stuff_due || !data_bit;
  assign lvl_next  = flip ? ~lvl : lvl;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lvl  <= LVL_J;
      ones <= '0;
    end else if (adv) begin
      lvl  <= lvl_next;
      ones <= flip ? '0 : ones + OW'(1);
    end
  end

  assert_run_limit_R5: assert property (@(posedge clk) disable iff (rst)
    ones <= OW'(STUFF_RUN));
  assert_stuff_toggles_R5: assert property (@(posedge clk) disable iff (rst)
    (adv && stuff_due && !clr) |=> (lvl != $past(lvl)) && (ones == '0));
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx #(
  parameter int CLKS_PER_BIT = 8,
  parameter int MIN_BYTES    = 2,
  parameter int MAX_BYTES    = 12,
  parameter int STUFF_RUN    = 6,
  parameter int CNT_W        = $clog2(MAX_BYTES + 1),
  parameter int ADDR_W       = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              dp_o,
  output logic              dm_o,
  output logic              oe_o,
  output logic              busy_o,
  output logic              done_o
);
  import usb_ls_tx_pkg::*;

  tx_state_t         state;
  logic [7:0]        shreg;
  logic [2:0]        bit_idx;
  logic [CNT_W-1:0]  left;
  logic              last_done;
  logic              se0_second;
  logic              tick, accept, adv, consume, stuff_due, lvl_next;

  usb_ls_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk(clk), .rst(rst), .run(state != TX_IDLE), .tick(tick)
  );

  usb_ls_nrzi #(.STUFF_RUN(STUFF_RUN)) u_nrzi (
    .clk(clk), .rst(rst), .clr(accept), .adv(adv),
    .data_bit(shreg[0]), .stuff_due(stuff_due), .lvl_next(lvl_next)
  );

  assign accept  = (state == TX_IDLE) && start_i;
  assign adv     = tick && ((state == TX_LEAD_J) ||
                   ((state == TX_BITS) && (stuff_due || !last_done)));
  assign consume = adv && !stuff_due;
  assign busy_o  = (state != TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= TX_IDLE;
      shreg      <= '0;
      bit_idx    <= '0;
      left       <= '0;
      last_done  <= 1'b0;
      se0_second <= 1'b0;
      rd_addr_o  <= '0;
      dp_o       <= 1'b0;
      dm_o       <= 1'b0;
      oe_o       <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        TX_IDLE: if (start_i) begin
          state     <= TX_LEAD_J;
          oe_o      <= 1'b1;
          dp_o      <= 1'b0;
          dm_o      <= 1'b1;
          shreg     <= SYNC_PATTERN;
          bit_idx   <= '0;
          left      <= nbytes_i - CNT_W'(1);
          rd_addr_o <= '0;
          last_done <= 1'b0;
        end
        TX_LEAD_J, TX_BITS: begin
          if (adv) begin
            state <= TX_BITS;
            dp_o  <= lvl_next;
            dm_o  <= ~lvl_next;
          end
          if (consume) begin
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) begin
              if (left == '0) begin
                last_done <= 1'b1;
              end else begin
                shreg     <= rd_data_i;
                left      <= left - CNT_W'(1);
                rd_addr_o <= rd_addr_o + ADDR_W'(1);
              end
            end else begin
              shreg <= {1'b0, shreg[7:1]};
            end
          end
          if (tick && state == TX_BITS && last_done && !stuff_due) begin
            state      <= TX_SE0;
            dp_o       <= 1'b0;
            dm_o       <= 1'b0;
            se0_second <= 1'b0;
          end
        end
        TX_SE0: if (tick) begin
          if (se0_second) begin
            state <= TX_TAIL_J;
            dp_o  <= 1'b0;
            dm_o  <= 1'b1;
          end else begin
            se0_second <= 1'b1;
          end
        end
        TX_TAIL_J: if (tick) begin
          state  <= TX_IDLE;
          oe_o   <= 1'b0;
          dp_o   <= 1'b0;
          dm_o   <= 1'b0;
          done_o <= 1'b1;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |-> (nbytes_i >= CNT_W'(MIN_BYTES) && nbytes_i <= CNT_W'(MAX_BYTES)));
  assert_released_low_R8: assert property (@(posedge clk) disable iff (rst)
    !oe_o |-> (!dp_o && !dm_o));
  assert_busy_drives_R2: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> oe_o);
  assert_lead_j_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (!dp_o && dm_o));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_done_at_release_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
  assert_tail_j_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_o) |-> ($past(dm_o) && !$past(dp_o)));
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !tick) |=> $stable(left) && $stable(rd_addr_o));
endmodule

// File: tb/tb_usb_ls_tx.sv
`timescale 1ns/1ps
module tb_usb_ls_tx;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [3:0] nbytes_i = 4'd0;
  logic [3:0] rd_addr_o;
  logic [7:0] rd_data_i;
  logic       dp_o, dm_o, oe_o, busy_o, done_o;

  logic [7:0] mem [0:15];
  int tests = 0;
  int fails = 0;
  int exp_sym [0:511];
  int nsym;

  always #2 clk = ~clk;
  assign rd_data_i = mem[rd_addr_o];

  usb_ls_tx #(.CLKS_PER_BIT(P)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .nbytes_i(nbytes_i),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .dp_o(dp_o), .dm_o(dm_o),
    .oe_o(oe_o), .busy_o(busy_o), .done_o(done_o)
  );

  // symbol codes: 0 = J, 1 = K, 2 = SE0, 3 = invalid
  function automatic int sym_now();
    case ({dp_o, dm_o})
      2'b01:   return 0;
      2'b10:   return 1;
      2'b00:   return 2;
      default: return 3;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic build_expected(input int n);
    int lvl = 0;
    int ones = 0;
    nsym = 0;
    exp_sym[nsym++] = 0;
    for (int b = 0; b < n; b++) begin
      logic [7:0] v = (b == 0) ? 8'h80 : mem[b-1];
      for (int i = 0; i < 8; i++) begin
        if (v[i]) ones++;
        else begin lvl = 1 - lvl; ones = 0; end
        exp_sym[nsym++] = lvl;
        if (ones == 6) begin
          lvl = 1 - lvl; ones = 0;
          exp_sym[nsym++] = lvl;
        end
      end
    end
    exp_sym[nsym++] = 2;
    exp_sym[nsym++] = 2;
    exp_sym[nsym++] = 0;
  endtask

  task automatic run_packet(input int n, input bit poke, input string name);
    int errs_body = 0;
    int errs_eop = 0;
    int first_act = -1;
    int first_exp = -1;
    build_expected(n);
    @(negedge clk);
    start_i = 1'b1; nbytes_i = 4'(n);
    @(negedge clk);
    start_i = 1'b0;
    chk(oe_o && busy_o && sym_now() == 0, {"R2 lead J and enable ", name}, sym_now(), 0);
    for (int c = 0; c < nsym * P; c++) begin
      if (c > 0) @(negedge clk);
      if (poke && c == 3*P) begin start_i = 1'b1; nbytes_i = 4'd2; end
      if (poke && c == 3*P + 1) start_i = 1'b0;
      if (sym_now() != exp_sym[c / P] || !oe_o || !busy_o) begin
        if (c >= (nsym - 3) * P) errs_eop++;
        else errs_body++;
        if (first_act < 0) begin first_act = sym_now(); first_exp = exp_sym[c / P]; end
      end
    end
    chk(errs_body == 0, {"R3 R4 R5 R6 symbol stream ", name}, first_act, first_exp);
    chk(errs_eop == 0, {"R7 end of packet ", name}, errs_eop, 0);
    if (poke) chk(errs_body + errs_eop == 0, {"R9 start while busy ", name}, errs_body + errs_eop, 0);
    @(negedge clk);
    chk(!oe_o && !dp_o && !dm_o && !busy_o && done_o, {"R8 release ", name},
        {27'd0, oe_o, dp_o, dm_o, busy_o, done_o}, 1);
    @(negedge clk);
    chk(!done_o && !busy_o, {"R8 done single cycle ", name}, done_o, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!oe_o && !dp_o && !dm_o && !busy_o && !done_o, "R1 during reset",
        {27'd0, oe_o, dp_o, dm_o, busy_o, done_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!oe_o && !busy_o && !done_o, "R1 after reset",
        {29'd0, oe_o, busy_o, done_o}, 0);
  endtask

  task automatic t_short();
    mem[0] = 8'h3C;
    run_packet(2, 1'b0, "short");
  endtask

  task automatic t_ones();
    for (int i = 0; i < 3; i++) mem[i] = 8'hFF;
    run_packet(4, 1'b0, "all ones");
  endtask

  task automatic t_zeros();
    mem[0] = 8'h00; mem[1] = 8'h00;
    run_packet(3, 1'b0, "all zeros");
  endtask

  task automatic t_full();
    for (int i = 0; i < 11; i++) mem[i] = 8'(i * 37 + 5);
    mem[4] = 8'hFE; mem[5] = 8'h7F;
    run_packet(12, 1'b0, "full length");
  endtask

  task automatic t_busy_start();
    mem[0] = 8'hA5; mem[1] = 8'h3F; mem[2] = 8'hFC; mem[3] = 8'h81;
    run_packet(5, 1'b1, "restart ignored");
  endtask

  task automatic t_tail_stuff();
    mem[0] = 8'h12; mem[1] = 8'hFC;
    run_packet(3, 1'b0, "trailing stuff");
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL R8 watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    t_reset();
    t_short();
    t_ones();
    t_zeros();
    t_full();
    t_busy_start();
    t_tail_stuff();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule